// File: doc/BRIEF.md
# Operate-Instruction Execute Unit with Condition Codes

This block executes the register-to-register part of a small 16-bit instruction set: addition, bitwise AND, bitwise complement, and the address-load instruction that adds a signed offset to the incremented program counter. It contains eight 16-bit general-purpose registers and a three-flag condition-code register. The flags record whether the last arithmetic or logic result was negative, zero or positive.

A sequencer presents one instruction word and its incremented PC together with a one-cycle valid strobe. In that cycle the unit decodes the fixed opcode and field positions and reads its source registers. It computes the result through a single shared adder/logic path. On the same clock edge it writes the destination register and, when the instruction calls for it, the flags. The written register index and value are reported on a write-back port for one cycle. Instructions may be issued on consecutive cycles. Fetch, memory access and control flow belong to other blocks.

Top module: `opexec_unit`

## Requirements
- R1: After reset every register reads as zero, the flags output `cc_nzp` (bit 2 = negative, bit 1 = zero, bit 0 = positive) equals 3'b010, and `wb_valid` is low.
- R2: Opcode 4'b0001 (bits [15:12]) adds the register named in bits [8:6] to the second operand, modulo 2^16, and writes the sum to the register named in bits [11:9].
- R3: Opcode 4'b0101 writes the bitwise AND of the register in bits [8:6] and the second operand to the register in bits [11:9].
- R4: For opcodes 0001 and 0101, bit 5 = 0 takes the second operand from the register in bits [2:0]. Bit 5 = 1 takes bits [4:0] as a signed literal from -16 to +15, sign-extended to 16 bits.
- R5: Opcode 4'b1001 with bits [5:0] = 6'b111111 writes the bitwise complement of the register in bits [8:6] to the register in bits [11:9]. With any other bits [5:0], the instruction is treated as unsupported.
- R6: Opcode 4'b1110 writes `pc_next` plus the sign-extended bits [8:0] to the register in bits [11:9] and leaves `cc_nzp` unchanged.
- R7: After opcodes 0001, 0101 and a well-formed 1001, exactly one flag is set, chosen from the written value: negative if bit 15 is 1, zero if the value is 0, and positive otherwise. The new flags are visible in the same cycle as the write-back report.
- R8: Any other opcode, or a malformed complement, leaves all registers and the flags unchanged, and `wb_valid` stays low.
- R9: `wb_valid` is high only in the cycle after a supported instruction is issued. In that cycle `wb_idx` and `wb_value` give the destination index and the value written.
- R10: An instruction issued in the cycle right after another one reads the register value that the earlier instruction wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | One-cycle strobe: `instr` and `pc_next` hold an instruction to execute |
| instr | input | 16 | Instruction word |
| pc_next | input | 16 | Incremented program counter of the instruction |
| wb_valid | output | 1 | A register was written at the last edge |
| wb_idx | output | 3 | Index of the register written |
| wb_value | output | 16 | Value written |
| cc_nzp | output | 3 | Condition codes {negative, zero, positive} |

## Verification
The bench builds the unit with its default parameters: a 16-bit data width and eight registers. With these defaults, every destination and source index in the fixed 3-bit fields can be reached. Both ends of the 5-bit literal range and the 9-bit offset range can be reached, as can carry-out wrap to zero and the sign bit that selects the negative flag. Random streams of back-to-back and gapped instructions, including unsupported opcodes, are compared against a register-file model held in the bench.

// File: rtl/opexec_pkg.sv
// Package: shared opcodes, function selects and the decoded-instruction record
// for the operate-instruction execute unit.
// Assumes: a fixed 16-bit instruction word with the opcode in bits [15:12].
package opexec_pkg;

    localparam int INSTR_W = 16;
    localparam int RIDX_W  = 3;
    localparam int NUM_GPR = 8;
    localparam int IMM_W   = 5;
    localparam int OFF_W   = 9;

    typedef enum logic [3:0] {
        OPC_ADD = 4'b0001,
        OPC_AND = 4'b0101,
        OPC_NOT = 4'b1001,
        OPC_LEA = 4'b1110
    } opcode_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_AND = 2'd1,
        FN_NOT = 2'd2,
        FN_LEA = 2'd3
    } alu_fn_e;

    typedef struct packed {
        logic               legal;
        alu_fn_e            fn;
        logic [RIDX_W-1:0]  dst;
        logic [RIDX_W-1:0]  src1;
        logic [RIDX_W-1:0]  src2;
        logic               use_imm;
        logic               cc_we;
        logic [IMM_W-1:0]   imm;
        logic [OFF_W-1:0]   off;
    } decoded_t;

endpackage

// File: rtl/opexec_decode.sv
// Module: opexec_decode
// Splits an instruction word into register indices, operand select, literal
// fields and control for the ALU and flag register. Purely combinational.
// Assumes: field positions are fixed; unsupported encodings set legal = 0.
module opexec_decode
    import opexec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output decoded_t           dec
);

    logic [3:0] opc;

    assign opc = instr[15:12];

    // Field extraction and legality check for each supported opcode.
    always_comb begin
        dec         = '0;
        dec.dst     = instr[11:9];
        dec.src1    = instr[8:6];
        dec.src2    = instr[2:0];
        dec.use_imm = instr[5];
        dec.imm     = instr[4:0];
        dec.off     = instr[8:0];
        dec.fn      = FN_ADD;
        unique case (opc)
            OPC_ADD: begin
                dec.legal = 1'b1;
                dec.fn    = FN_ADD;
                dec.cc_we = 1'b1;
            end
            OPC_AND: begin
                dec.legal = 1'b1;
                dec.fn    = FN_AND;
                dec.cc_we = 1'b1;
            end
            OPC_NOT: begin
                dec.legal = (instr[5:0] == 6'b111111);
                dec.fn    = FN_NOT;
                dec.cc_we = 1'b1;
            end
            OPC_LEA: begin
                dec.legal = 1'b1;
                dec.fn    = FN_LEA;
                dec.cc_we = 1'b0;
            end
            default: begin
                dec.legal = 1'b0;
                dec.cc_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/opexec_regfile.sv
// Module: opexec_regfile
// General-purpose register array with two combinational read ports and one
// synchronous write port. Every register clears on reset.
// Assumes: at most one write per cycle; a read in the cycle after a write sees it.
module opexec_regfile #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 8,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] gpr_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_gpr
        // One register: clear on reset, load when addressed by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gpr_q[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                gpr_q[g] <= wdata;
            end
        end
    end

    // Combinational read ports.
    always_comb begin
        rdata_a = gpr_q[raddr_a];
        rdata_b = gpr_q[raddr_b];
    end

    // A write lands: the addressed register reads back the written data next cycle.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (raddr_a == waddr)) |=> (gpr_q[$past(waddr)] == $past(wdata)))
        else $error("register write did not land");

endmodule

// File: rtl/opexec_alu.sv
// Module: opexec_alu
// Result path shared by all four instructions. One adder serves both the
// register/literal sum and the PC-plus-offset address. AND and complement
// are bitwise.
// Assumes: literal and offset fields arrive unextended; DATA_W >= OFF_W.
module opexec_alu
    import opexec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_e            fn,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic               use_imm,
    input  logic [IMM_W-1:0]   imm,
    input  logic [OFF_W-1:0]   off,
    input  logic [DATA_W-1:0]  pc,
    output logic [DATA_W-1:0]  result
);

    localparam int IMM_PAD = DATA_W - IMM_W;
    localparam int OFF_PAD = DATA_W - OFF_W;

    logic [DATA_W-1:0] imm_x;
    logic [DATA_W-1:0] off_x;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] add_a;
    logic [DATA_W-1:0] add_b;
    logic [DATA_W-1:0] sum;

    // Sign-extend the literal and offset fields and select the second operand.
    always_comb begin
        imm_x  = {{IMM_PAD{imm[IMM_W-1]}}, imm};
        off_x  = {{OFF_PAD{off[OFF_W-1]}}, off};
        opnd_b = use_imm ? imm_x : src_b;
    end

    // Shared adder: operands switch to PC and offset for address loads.
    always_comb begin
        add_a = (fn == FN_LEA) ? pc    : src_a;
        add_b = (fn == FN_LEA) ? off_x : opnd_b;
        sum   = add_a + add_b;
    end

    // Final result selection.
    always_comb begin
        unique case (fn)
            FN_AND:  result = src_a & opnd_b;
            FN_NOT:  result = ~src_a;
            default: result = sum;
        endcase
    end

endmodule

// File: rtl/opexec_flags.sv
// Module: opexec_flags
// Condition-code register {negative, zero, positive}. It is loaded from the
// write-back value only when its write enable is high.
// Assumes: the value presented is the one being written to a register.
module opexec_flags #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cc_we,
    input  logic [DATA_W-1:0] value,
    output logic [2:0]        cc_q
);

    logic [2:0] cc_d;

    // Classify the value by its sign bit and zero state.
    always_comb begin
        if (value[DATA_W-1]) begin
            cc_d = 3'b100;
        end else if (value == '0) begin
            cc_d = 3'b010;
        end else begin
            cc_d = 3'b001;
        end
    end

    // Flag register: zero flag after reset, selective update otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q <= 3'b010;
        end else if (cc_we) begin
            cc_q <= cc_d;
        end
    end

    // Exactly one flag is set at all times after reset.
    p_one_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc_q) == 1)
        else $error("flags not one-hot");

    // Without an update the flags hold.
    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_we |=> $stable(cc_q))
        else $error("flags changed without update");

endmodule

// File: rtl/opexec_unit.sv
// Module: opexec_unit (top)
// Executes add, AND, complement and address-load instructions in one cycle.
// It writes the register file and optionally the flags, and reports the
// write-back on registered outputs.
// Assumes: issue_valid is a one-cycle strobe per instruction; instr and
// pc_next are stable while it is high.
module opexec_unit
    import opexec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   pc_next,
    output logic                wb_valid,
    output logic [RIDX_W-1:0]   wb_idx,
    output logic [DATA_W-1:0]   wb_value,
    output logic [2:0]          cc_nzp
);

    decoded_t          dec;
    logic [DATA_W-1:0] rd_a;
    logic [DATA_W-1:0] rd_b;
    logic [DATA_W-1:0] alu_res;
    logic              exec_fire;

    opexec_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    opexec_regfile #(
        .DATA_W (DATA_W),
        .NREGS  (NUM_GPR)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (exec_fire),
        .waddr   (dec.dst),
        .wdata   (alu_res),
        .raddr_a (dec.src1),
        .raddr_b (dec.src2),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    opexec_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .fn      (dec.fn),
        .src_a   (rd_a),
        .src_b   (rd_b),
        .use_imm (dec.use_imm),
        .imm     (dec.imm),
        .off     (dec.off),
        .pc      (pc_next),
        .result  (alu_res)
    );

    opexec_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .cc_we (exec_fire && dec.cc_we),
        .value (alu_res),
        .cc_q  (cc_nzp)
    );

    // An instruction executes only when strobed and supported.
    assign exec_fire = issue_valid && dec.legal;

    // Write-back report register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_idx   <= '0;
            wb_value <= '0;
        end else begin
            wb_valid <= exec_fire;
            if (exec_fire) begin
                wb_idx   <= dec.dst;
                wb_value <= alu_res;
            end
        end
    end

    // No write-back report without an issue strobe in the previous cycle.
    p_wb_needs_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !wb_valid)
        else $error("write-back without issue");

    // Unsupported encodings produce no write-back.
    p_bad_op_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !dec.legal) |=> !wb_valid)
        else $error("unsupported opcode wrote back");

    // Address loads leave the flags alone.
    p_lea_keeps_cc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && (instr[15:12] == OPC_LEA)) |=> $stable(cc_nzp))
        else $error("address load changed flags");

    // Flags agree with the reported value after a flag-setting instruction.
    p_cc_matches_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && dec.legal && dec.cc_we) |=>
            (cc_nzp == {wb_value[DATA_W-1], wb_value == '0,
                        !wb_value[DATA_W-1] && (wb_value != '0)}))
        else $error("flags disagree with write-back");

endmodule

// File: tb/test_opexec_unit.sv
`timescale 1ns/100ps
module test_opexec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc_next = '0;
    logic        wb_valid;
    logic [2:0]  wb_idx;
    logic [15:0] wb_value;
    logic [2:0]  cc_nzp;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] m_reg [8];
    logic [2:0]  m_cc;

    always #2.5 clk = ~clk;

    opexec_unit i_opexec_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .instr       (instr),
        .pc_next     (pc_next),
        .wb_valid    (wb_valid),
        .wb_idx      (wb_idx),
        .wb_value    (wb_value),
        .cc_nzp      (cc_nzp)
    );

    function automatic logic [15:0] sx5(input logic [4:0] v);
        return {{11{v[4]}}, v};
    endfunction

    function automatic logic [15:0] sx9(input logic [8:0] v);
        return {{7{v[8]}}, v};
    endfunction

    function automatic logic [2:0] nzp_of(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic [15:0] e_add_r(input int d, input int a, input int b);
        return {4'b0001, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] e_add_i(input int d, input int a, input int imm);
        return {4'b0001, 3'(d), 3'(a), 1'b1, 5'(imm)};
    endfunction
    function automatic logic [15:0] e_and_r(input int d, input int a, input int b);
        return {4'b0101, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] e_and_i(input int d, input int a, input int imm);
        return {4'b0101, 3'(d), 3'(a), 1'b1, 5'(imm)};
    endfunction
    function automatic logic [15:0] e_not(input int d, input int a);
        return {4'b1001, 3'(d), 3'(a), 6'b111111};
    endfunction
    function automatic logic [15:0] e_lea(input int d, input int off);
        return {4'b1110, 3'(d), 9'(off)};
    endfunction

    task automatic check(input string tag, input logic ev, input logic [2:0] ei,
                         input logic [15:0] evl, input logic [2:0] ec);
        bit ok;
        n_chk++;
        ok = (wb_valid === ev) && (cc_nzp === ec) &&
             (!ev || ((wb_idx === ei) && (wb_value === evl)));
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got v=%b idx=%0d val=%h cc=%b, exp v=%b idx=%0d val=%h cc=%b",
                     tag, wb_valid, wb_idx, wb_value, cc_nzp, ev, ei, evl, ec);
        end
    endtask

    // Issue one instruction at a falling edge and check the report one cycle later.
    task automatic issue(input logic [15:0] ins, input logic [15:0] pc, input string tag);
        logic        ev;
        logic [2:0]  ei;
        logic [15:0] evl;
        logic [15:0] a;
        logic [15:0] b;
        a   = m_reg[ins[8:6]];
        b   = ins[5] ? sx5(ins[4:0]) : m_reg[ins[2:0]];
        ei  = ins[11:9];
        ev  = 1'b1;
        evl = '0;
        case (ins[15:12])
            4'b0001: evl = a + b;
            4'b0101: evl = a & b;
            4'b1001: begin
                if (ins[5:0] == 6'b111111) evl = ~a;
                else ev = 1'b0;
            end
            4'b1110: evl = pc + sx9(ins[8:0]);
            default: ev = 1'b0;
        endcase
        if (ev) begin
            m_reg[ei] = evl;
            if (ins[15:12] != 4'b1110) m_cc = nzp_of(evl);
        end
        issue_valid = 1'b1;
        instr       = ins;
        pc_next     = pc;
        @(negedge clk);
        issue_valid = 1'b0;
        instr       = 16'($urandom);
        check(tag, ev, ei, evl, m_cc);
    endtask

    task automatic idle_cycle(input string tag);
        issue_valid = 1'b0;
        @(negedge clk);
        check(tag, 1'b0, 3'd0, 16'h0, m_cc);
    endtask

    function automatic string tag_of(input logic [15:0] ins);
        case (ins[15:12])
            4'b0001: return "R2";
            4'b0101: return "R3";
            4'b1001: return (ins[5:0] == 6'b111111) ? "R5" : "R8";
            4'b1110: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0e1c));
        for (int i = 0; i < 8; i++) m_reg[i] = 16'h0;
        m_cc = 3'b010;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports.
        check("R1", 1'b0, 3'd0, 16'h0, 3'b010);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 3'd0, 16'h0, 3'b010);
        // R1: every register reads zero (read back through an add of zero).
        for (int r = 0; r < 8; r++) issue(e_add_i(r, r, 0), 16'h0, "R1");

        // R4: literal bounds; R2 sum.
        issue(e_add_i(1, 0, 15), 16'h0, "R4");
        issue(e_add_i(2, 0, -16), 16'h0, "R4");
        // R10: back-to-back reads of the two registers just written; R2 register mode.
        issue(e_add_r(3, 1, 2), 16'h0, "R10");
        // R2: wrap to zero sets the zero flag (R7).
        issue(e_add_i(4, 3, 1), 16'h0, "R7");
        // R3: register and literal AND.
        issue(e_and_r(5, 3, 1), 16'h0, "R3");
        issue(e_and_i(5, 2, -1), 16'h0, "R3");
        // R5: complement.
        issue(e_not(6, 1), 16'h0, "R5");
        // R6: address loads keep flags, negative and positive offsets, PC wrap.
        issue(e_lea(7, -1), 16'h3000, "R6");
        issue(e_lea(7, 255), 16'h3000, "R6");
        issue(e_lea(0, -256), 16'h0010, "R6");
        issue(e_add_i(0, 0, 0), 16'h0, "R6");
        // R8: malformed complement and unsupported opcodes change nothing.
        issue({4'b1001, 3'd6, 3'd1, 6'b111110}, 16'h0, "R8");
        issue({4'b0000, 3'd6, 9'h1FF}, 16'h0, "R8");
        issue({4'b1111, 3'd6, 9'h025}, 16'h0, "R8");
        issue(e_and_i(6, 6, -1), 16'h0, "R8");
        // R9: idle cycles give no write-back.
        idle_cycle("R9");
        idle_cycle("R9");

        // Random mix, back-to-back with occasional gaps.
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] ins;
            logic [15:0] pc;
            int kind;
            kind = int'($urandom_range(0, 9));
            pc   = 16'($urandom);
            case (kind)
                0, 1: ins = $urandom_range(0, 1) ? e_add_r($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7))
                                                 : e_add_i($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 31));
                2, 3: ins = $urandom_range(0, 1) ? e_and_r($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7))
                                                 : e_and_i($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 31));
                4:    ins = e_not($urandom_range(0, 7), $urandom_range(0, 7));
                5, 6: ins = e_lea($urandom_range(0, 7), $urandom_range(0, 511));
                7:    ins = {4'b1001, 6'($urandom), 6'($urandom_range(0, 62))};
                default: begin
                    logic [3:0] op;
                    op = 4'($urandom);
                    while (op == 4'b0001 || op == 4'b0101 || op == 4'b1001 || op == 4'b1110)
                        op = 4'($urandom);
                    ins = {op, 12'($urandom)};
                end
            endcase
            issue(ins, pc, tag_of(ins));
            if ($urandom_range(0, 5) == 0) idle_cycle("R9");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule